// File: doc/BRIEF.md
# Serial-Programmed Clock Output Gate

This block fans one reference clock out to fourteen clock outputs. Each output has its own enable bit. When the bit is set, the output follows the reference clock. When the bit is clear, the output is held low. A two-wire serial bus writes the enable bits. It uses SMBus-style block writes to a fixed 7-bit slave address: START, address with the write flag, a command byte, a byte-count byte, and then up to three payload bytes.

The bus is write-only. The slave pulls the data line low to acknowledge every byte it accepts. Payload bytes after the third are acknowledged and dropped. A separate output-enable input turns off the drivers of all fourteen outputs, whatever the register holds. The outputs are core-side signals: each output has a value and a driver-enable, and the pad ring turns the pair into a high-impedance pin. The bus lines are synchronised into the system clock before edge detection.

Top module: `clkout_gate_top`

## Requirements
- R1: The slave acknowledges only address 1101001 (bit 6 down to bit 0) with the R/W bit equal to 0. Any other address, or a read, gets no acknowledge on any byte of the frame, and the enable pattern stays unchanged.
- R2: In an accepted frame, the slave pulls SDA low during the ninth clock of each byte: address, command, count and every payload byte.
- R3: Serial bits arrive MSB first. The first payload byte (after the command and count bytes) maps bits 7,6,3,2,1,0 onto outputs 5,4,3,2,1,0.
- R4: The second payload byte maps bits 7,6,5,4,1,0 onto outputs 11,10,9,8,7,6.
- R5: The third payload byte maps bit 7 onto output 13 and bit 6 onto output 12. Any fourth or later payload byte is acknowledged and changes nothing.
- R6: Reserved bit positions are ignored. These are bits 5:4 of payload byte 0, bits 3:2 of payload byte 1 and bits 5:0 of payload byte 2. They affect no output.
- R7: After reset, all fourteen enable bits are 1.
- R8: When `oe` is 0, every bit of `clk_out_oe` is 0. When `oe` is 1, every bit is 1.
- R9: An enabled output equals `clk_in`. A disabled output is 0.
- R10: A new enable value reaches an output only while `clk_in` is low. While `clk_in` stays high, the outputs keep their previous pattern.
- R11: A STOP or repeated START in the middle of a byte discards that byte, and no enable bit changes.
- R12: The command byte and the byte-count byte that follow the address are acknowledged and never written into the enable pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the bus logic and the enable registers |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial bus clock line (asynchronous) |
| sda_in | input | 1 | Serial bus data line as seen on the wire (asynchronous) |
| sda_pull | output | 1 | 1 pulls the data line low (open-drain acknowledge) |
| clk_in | input | 1 | Reference clock to be fanned out |
| oe | input | 1 | Global output enable for all output drivers |
| clk_out | output | 14 | Gated copies of the reference clock |
| clk_out_oe | output | 14 | Per-output driver enable for the pad ring |

## Verification
The hardest case to reach is a frame that is cut off partway. The cut can be a STOP or a repeated START a few bits into a payload byte, after earlier bytes of the same frame have already been committed. The bench master can stop partway through any byte. It first commits a full payload byte, then aborts the next byte, so the expected pattern mixes new and old bits. A second hard case is an enable change while the reference clock is held high. The bench owns the reference clock, keeps it high through a whole write, and checks that the outputs keep the old pattern until the clock next goes low.

// File: rtl/clkout_gate_pkg.sv
package clkout_gate_pkg;

    localparam int          N_OUT    = 14;
    localparam int          N_PAY    = 3;
    localparam logic [6:0]  DEV_ADDR = 7'b1101001;
    localparam int          BIT_W    = 4;
    localparam int          IDX_W    = 2;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_CMD,
        PH_CNT,
        PH_DATA
    } phase_t;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
        logic [7:0]       data;
    } pay_wr_t;

    // Merge one payload byte into the enable vector; reserved positions are skipped.
    function automatic logic [N_OUT-1:0] merge_byte(
        input logic [N_OUT-1:0] cur,
        input logic [IDX_W-1:0] idx,
        input logic [7:0]       d
    );
        logic [N_OUT-1:0] r;
        r = cur;
        case (idx)
            2'd0: begin
                r[5]   = d[7];
                r[4]   = d[6];
                r[3:0] = d[3:0];
            end
            2'd1: begin
                r[11:8] = d[7:4];
                r[7:6]  = d[1:0];
            end
            2'd2: begin
                r[13] = d[7];
                r[12] = d[6];
            end
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) pipe[0] <= '1;
        else     pipe[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pipe[s] <= '1;
            else     pipe[s] <= pipe[s-1];
        end
    end

    assign dout = pipe[STAGES-1];

endmodule

// File: rtl/serial_wr_slave.sv
module serial_wr_slave
    import clkout_gate_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_s,
    input  logic    sda_s,
    output logic    sda_pull,
    output pay_wr_t wr
);

    logic             scl_q, sda_q;
    phase_t           phase, nxt_phase;
    logic [BIT_W-1:0] bit_cnt;
    logic [7:0]       shreg;
    logic             in_ack;
    logic             ack_drv;
    logic [IDX_W-1:0] pay_idx;

    logic start_c, stop_c, scl_rise, scl_fall, addr_hit;

    assign start_c  = scl_s && scl_q && sda_q && !sda_s;
    assign stop_c   = scl_s && scl_q && !sda_q && sda_s;
    assign scl_rise = scl_s && !scl_q;
    assign scl_fall = !scl_s && scl_q;
    assign addr_hit = (shreg[7:1] == DEV_ADDR) && !shreg[0];
    assign sda_pull = ack_drv;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q     <= 1'b1;
            sda_q     <= 1'b1;
            phase     <= PH_IDLE;
            nxt_phase <= PH_IDLE;
            bit_cnt   <= '0;
            shreg     <= '0;
            in_ack    <= 1'b0;
            ack_drv   <= 1'b0;
            pay_idx   <= '0;
            wr        <= '0;
        end else begin
            scl_q    <= scl_s;
            sda_q    <= sda_s;
            wr.valid <= 1'b0;
            if (start_c) begin
                phase   <= PH_ADDR;
                bit_cnt <= '0;
                in_ack  <= 1'b0;
                ack_drv <= 1'b0;
                pay_idx <= '0;
            end else if (stop_c) begin
                phase   <= PH_IDLE;
                bit_cnt <= '0;
                in_ack  <= 1'b0;
                ack_drv <= 1'b0;
            end else if (phase != PH_IDLE) begin
                if (scl_rise && !in_ack) begin
                    shreg   <= {shreg[6:0], sda_s};
                    bit_cnt <= bit_cnt + 1'b1;
                end
                if (scl_fall) begin
                    if (in_ack) begin
                        in_ack  <= 1'b0;
                        ack_drv <= 1'b0;
                        phase   <= nxt_phase;
                        bit_cnt <= '0;
                    end else if (bit_cnt == BIT_W'(8)) begin
                        bit_cnt <= '0;
                        case (phase)
                            PH_ADDR: begin
                                if (addr_hit) begin
                                    in_ack    <= 1'b1;
                                    ack_drv   <= 1'b1;
                                    nxt_phase <= PH_CMD;
                                end else begin
                                    phase <= PH_IDLE;
                                end
                            end
                            PH_CMD: begin
                                in_ack    <= 1'b1;
                                ack_drv   <= 1'b1;
                                nxt_phase <= PH_CNT;
                            end
                            PH_CNT: begin
                                in_ack    <= 1'b1;
                                ack_drv   <= 1'b1;
                                nxt_phase <= PH_DATA;
                            end
                            PH_DATA: begin
                                in_ack    <= 1'b1;
                                ack_drv   <= 1'b1;
                                nxt_phase <= PH_DATA;
                                if (pay_idx < IDX_W'(N_PAY)) begin
                                    wr.valid <= 1'b1;
                                    wr.idx   <= pay_idx;
                                    wr.data  <= shreg;
                                    pay_idx  <= pay_idx + 1'b1;
                                end
                            end
                            default: phase <= PH_IDLE;
                        endcase
                    end
                end
            end
        end
    end

endmodule

// File: rtl/enable_regs.sv
module enable_regs
    import clkout_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  pay_wr_t          wr,
    output logic [N_OUT-1:0] en_q
);

    always_ff @(posedge clk) begin
        if (rst)           en_q <= '1;
        else if (wr.valid) en_q <= merge_byte(en_q, wr.idx, wr.data);
    end

endmodule

// File: rtl/clk_fanout.sv
module clk_fanout #(
    parameter int N = 14
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clk_in,
    input  logic         oe,
    input  logic [N-1:0] en_q,
    output logic [N-1:0] en_eff,
    output logic [N-1:0] out,
    output logic [N-1:0] out_oe
);

    for (genvar i = 0; i < N; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)         en_eff[i] <= 1'b1;
            else if (!clk_in) en_eff[i] <= en_q[i];
        end
        assign out[i]    = clk_in & en_eff[i];
        assign out_oe[i] = oe;
    end

endmodule

// File: rtl/clkout_gate_top.sv
module clkout_gate_top
    import clkout_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             sda_pull,
    input  logic             clk_in,
    input  logic             oe,
    output logic [N_OUT-1:0] clk_out,
    output logic [N_OUT-1:0] clk_out_oe
);

    logic [1:0]       bus_s;
    pay_wr_t          wr_bus;
    logic             wr_valid;
    logic [N_OUT-1:0] en_q;
    logic [N_OUT-1:0] en_eff;

    bus_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({scl_in, sda_in}),
        .dout (bus_s)
    );

    serial_wr_slave u_slave (
        .clk      (clk),
        .rst      (rst),
        .scl_s    (bus_s[1]),
        .sda_s    (bus_s[0]),
        .sda_pull (sda_pull),
        .wr       (wr_bus)
    );

    assign wr_valid = wr_bus.valid;

    enable_regs u_regs (
        .clk  (clk),
        .rst  (rst),
        .wr   (wr_bus),
        .en_q (en_q)
    );

    clk_fanout #(.N(N_OUT)) u_fan (
        .clk    (clk),
        .rst    (rst),
        .clk_in (clk_in),
        .oe     (oe),
        .en_q   (en_q),
        .en_eff (en_eff),
        .out    (clk_out),
        .out_oe (clk_out_oe)
    );

endmodule

// File: rtl/clkout_gate_checker.sv
module clkout_gate_checker
    import clkout_gate_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             clk_in,
    input logic             oe,
    input logic             scl_s,
    input logic             sda_pull,
    input logic             wr_valid,
    input logic [N_OUT-1:0] en_q,
    input logic [N_OUT-1:0] en_eff,
    input logic [N_OUT-1:0] clk_out,
    input logic [N_OUT-1:0] clk_out_oe
);

    p_reset_all_on_r7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (en_q == '1 && en_eff == '1));

    p_glitch_free_r10: assert property (@(posedge clk) disable iff (rst)
        (en_eff != $past(en_eff)) |-> !$past(clk_in));

    p_reg_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (en_q != $past(en_q)) |-> $past(wr_valid));

    p_ack_scl_low_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> !scl_s);

    p_low_when_ref_low_r9: assert property (@(posedge clk) disable iff (rst)
        !clk_in |-> (clk_out == '0));

    p_drivers_off_r8: assert property (@(posedge clk) disable iff (rst)
        !oe |-> (clk_out_oe == '0));

endmodule

bind clkout_gate_top clkout_gate_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .clk_in     (clk_in),
    .oe         (oe),
    .scl_s      (bus_s[1]),
    .sda_pull   (sda_pull),
    .wr_valid   (wr_valid),
    .en_q       (en_q),
    .en_eff     (en_eff),
    .clk_out    (clk_out),
    .clk_out_oe (clk_out_oe)
);

// File: tb/tb_clkout_gate_top.sv
module tb_clkout_gate_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        src = 1'b0;
    logic        oe = 1'b1;
    logic        sda_pull;
    logic        sda_line;
    logic [13:0] clk_out;
    logic [13:0] clk_out_oe;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    clkout_gate_top dut (
        .clk        (clk),
        .rst        (rst),
        .scl_in     (scl_m),
        .sda_in     (sda_line),
        .sda_pull   (sda_pull),
        .clk_in     (src),
        .oe         (oe),
        .clk_out    (clk_out),
        .clk_out_oe (clk_out_oe)
    );

    // {payload0, payload1, payload2, expected enable pattern}
    localparam logic [39:0] VEC [11] = '{
        {8'h00, 8'h00, 8'h00, 16'h0000},
        {8'hFF, 8'hFF, 8'hFF, 16'h3FFF},
        {8'h80, 8'h00, 8'h00, 16'h0020},
        {8'h0F, 8'h00, 8'h00, 16'h000F},
        {8'h40, 8'h00, 8'h00, 16'h0010},
        {8'h30, 8'h0C, 8'h3F, 16'h0000},
        {8'h00, 8'hF0, 8'h00, 16'h0F00},
        {8'h00, 8'h03, 8'h00, 16'h00C0},
        {8'h00, 8'h00, 8'h80, 16'h2000},
        {8'h00, 8'h00, 8'h40, 16'h1000},
        {8'hA5, 8'h5A, 8'hC0, 16'h35A5}
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic hb();
        repeat (8) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hb();
        scl_m = 1'b1; hb();
        sda_m = 1'b0; hb();
        scl_m = 1'b0; hb();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hb();
        scl_m = 1'b1; hb();
        sda_m = 1'b1; hb();
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            sda_m = b[i]; hb();
            scl_m = 1'b1; hb();
            scl_m = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        send_bits(b, 8);
        sda_m = 1'b1; hb();
        scl_m = 1'b1;
        repeat (4) @(negedge clk);
        acked = (sda_line == 1'b0);
        repeat (4) @(negedge clk);
        scl_m = 1'b0; hb();
    endtask

    // Full frame: address, command, count, then n payload bytes; returns number of acks.
    task automatic frame(input logic [7:0] addr, input logic [7:0] d0, input logic [7:0] d1,
                         input logic [7:0] d2, input logic [7:0] d3, input int n, output int acks);
        logic a;
        logic [7:0] pay [4];
        pay = '{d0, d1, d2, d3};
        acks = 0;
        bus_start();
        send_byte(addr, a);  acks += int'(a);
        send_byte(8'hFF, a); acks += int'(a);
        send_byte(8'(n), a); acks += int'(a);
        for (int k = 0; k < n; k++) begin
            send_byte(pay[k], a); acks += int'(a);
        end
        bus_stop();
    endtask

    task automatic pattern(input logic [13:0] exp, input string tag);
        src = 1'b0; repeat (3) @(negedge clk);
        src = 1'b1; repeat (2) @(negedge clk);
        chk(32'(clk_out), 32'(exp), tag);
        src = 1'b0; repeat (2) @(negedge clk);
        chk(32'(clk_out), 32'h0, {tag, " low phase (R9)"});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int acks;
        logic a;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R7 reset state, R8 drivers on
        pattern(14'h3FFF, "R7 reset all enabled");
        chk(32'(clk_out_oe), 32'h3FFF, "R8 drivers on with oe=1");

        // R10: write zeros while reference clock held high
        src = 1'b1; repeat (2) @(negedge clk);
        frame(8'hD2, 8'h00, 8'h00, 8'h00, 8'h00, 3, acks);
        repeat (4) @(negedge clk);
        chk(32'(clk_out), 32'h3FFF, "R10 old pattern kept while clk_in high");
        pattern(14'h0000, "R10 new pattern after clk_in low");

        // R3 R4 R5 R6 R12 R2: table walk
        foreach (VEC[v]) begin
            frame(8'hD2, VEC[v][39:32], VEC[v][31:24], VEC[v][23:16], 8'h00, 3, acks);
            chk(32'(acks), 32'd6, "R2 R12 acks on addr, cmd, count and payload");
            pattern(VEC[v][13:0], "R3 R4 R5 R6 mapping vector");
        end

        // R1: wrong address and read bit
        frame(8'hD4, 8'h00, 8'h00, 8'h00, 8'h00, 3, acks);
        chk(32'(acks), 32'd0, "R1 no ack for other address");
        pattern(14'h35A5, "R1 pattern unchanged after other address");
        frame(8'hD3, 8'h00, 8'h00, 8'h00, 8'h00, 3, acks);
        chk(32'(acks), 32'd0, "R1 no ack for read");
        pattern(14'h35A5, "R1 pattern unchanged after read");

        // R11: commit byte 0, abort byte 1 with STOP
        bus_start();
        send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h03, a);
        send_byte(8'h00, a);
        send_bits(8'h00, 4);
        hb();
        bus_stop();
        pattern(14'h3580, "R11 partial byte dropped on stop");

        // R11: abort mid-byte with repeated START
        bus_start();
        send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h03, a);
        send_bits(8'hFF, 3);
        hb();
        bus_start();
        bus_stop();
        pattern(14'h3580, "R11 partial byte dropped on repeated start");

        // R5: surplus payload byte acknowledged and discarded
        frame(8'hD2, 8'hFF, 8'hFF, 8'hFF, 8'h00, 4, acks);
        chk(32'(acks), 32'd7, "R5 surplus byte acknowledged");
        pattern(14'h3FFF, "R5 surplus byte has no effect");

        // R8: global output enable off
        oe = 1'b0; repeat (2) @(negedge clk);
        chk(32'(clk_out_oe), 32'h0, "R8 drivers off with oe=0");
        oe = 1'b1; repeat (2) @(negedge clk);
        chk(32'(clk_out_oe), 32'h3FFF, "R8 drivers back on");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule